// File: doc/BRIEF.md
# Redial Buffer and Dial Sequencer

This block sits between a debounced keypad front end and the tone and pulse signalling engines of a line-powered telephone. Each accepted key code is either written into a 32-entry circular number store and queued for signalling, or acted on as a function key. The sequencer walks the queue one entry at a time. It hands each dialable code to the signalling engine and waits for that engine's done strobe before it moves on. A stored pause entry becomes a timed silence. A stored tone-switch marker moves signalling from pulse to tone.

A single shared key stands for both "redial" and "pause", and its meaning depends on history. Straight after going off-hook or after a hook-flash break it replays the stored number. After a digit it records a pause. A flash key requests a timed line break once every queued entry has been signalled. The number store is kept across the break, and the first digit keyed after the break starts a new number. Any change on the hook input aborts whatever is in progress. All timing is counted on a 1 ms tick input.

Top module: `redial_sequencer`

## Requirements
- R1: While reset is asserted and immediately after it, `dial_req` and `line_break` are low.
- R2: A dialable key (codes 0 to 9, 10 for star, 11 for hash) keyed off-hook raises `dial_req` with that code in `dial_code` after a pre-signal delay of `PRESIG_TICKS` ticks. The request and code are held until `sig_done` is seen. Queued entries go out in keying order.
- R3: Code 12 keyed after a digit stores a pause. When it is reached, the next entry goes out after `PAUSE_TONE_TICKS` ticks if `dial_tone` is high, or `PAUSE_PULSE_TICKS` ticks if it is low.
- R4: Code 12 keyed as the first key after going off-hook replays the stored entries from the oldest, one per `sig_done`. Keys are ignored until the replay finishes.
- R5: Once more than 32 entries have been keyed in one number, a replay yields only the most recent 32, oldest first.
- R6: Code 13 (flash) holds `line_break` high for `FLASH_TICKS` ticks after all queued entries have been signalled. Keys are ignored from the flash key until the break ends.
- R7: After a flash break, code 12 replays the number that was stored before the break. A dialable key instead starts a new number that replaces the stored one.
- R8: A change on `off_hook` drops `dial_req` and `line_break` on the next cycle, discards unsignalled entries, and reloads `dial_tone` from `tone_default`.
- R9: A replay request with nothing stored produces no request. Stored entries survive an on-hook period.
- R10: Code 14 stores a tone-switch marker. When the sequencer reaches it, live or on replay, `dial_tone` goes high. Only a hook change brings it back low.
- R11: Keys presented while on-hook are ignored and leave the stored number unchanged. Code 15 is ignored in every state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle strobe per millisecond |
| off_hook | input | 1 | High while the handset is off-hook |
| tone_default | input | 1 | Signalling mode loaded on each hook change: 1 tone, 0 pulse |
| key_valid | input | 1 | One-cycle strobe for a debounced key |
| key_code | input | 4 | Key code, valid with `key_valid` |
| sig_done | input | 1 | Signalling engine finished the current request |
| dial_req | output | 1 | Request to signal `dial_code` |
| dial_code | output | 4 | Code to signal while `dial_req` is high |
| dial_tone | output | 1 | Current signalling mode: 1 tone, 0 pulse |
| line_break | output | 1 | Timed hook-flash break active |

## Verification
The control state in this block is mostly invisible until a later key arrives. A wrong pointer or entry count first shows when a replay starts at the wrong entry or emits the wrong number of codes. That can be a full number later, so the bench replays after every kind of history: a plain number, a wrapped number, a flash, and an on-hook gap. A wrong meaning for the shared key shows within one pre-signal delay, as a replay where a pause was wanted or the other way round. A wrong pause or break length appears only at the end of a window of thousands of cycles, so those gaps are measured against their limits.

// File: rtl/redial_pkg.sv
package redial_pkg;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] KEY_LAST_DIALABLE = 4'd11;
    localparam logic [CODE_W-1:0] KEY_PAUSE_REDIAL  = 4'd12;
    localparam logic [CODE_W-1:0] KEY_FLASH         = 4'd13;
    localparam logic [CODE_W-1:0] KEY_TONE_SWITCH   = 4'd14;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PRESIG,
        SQ_FETCH,
        SQ_ISSUE,
        SQ_PAUSE,
        SQ_BREAK
    } seq_state_e;

endpackage

// File: rtl/dial_store.sv
module dial_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/dial_timer.sv
module dial_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);

    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run && tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = run && tick && (cnt_q == limit - 1'b1);

endmodule

// File: rtl/redial_sequencer.sv
module redial_sequencer
    import redial_pkg::*;
#(
    parameter int DEPTH             = 32,
    parameter int PRESIG_TICKS      = 8,
    parameter int PAUSE_TONE_TICKS  = 3100,
    parameter int PAUSE_PULSE_TICKS = 3000,
    parameter int FLASH_TICKS       = 585
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic              off_hook,
    input  logic              tone_default,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    input  logic              sig_done,
    output logic              dial_req,
    output logic [CODE_W-1:0] dial_code,
    output logic              dial_tone,
    output logic              line_break
);

    localparam int AW     = $clog2(DEPTH);
    localparam int LW     = AW + 1;
    localparam int MAX_AB = (PAUSE_TONE_TICKS > PAUSE_PULSE_TICKS) ? PAUSE_TONE_TICKS : PAUSE_PULSE_TICKS;
    localparam int MAX_CD = (FLASH_TICKS > PRESIG_TICKS) ? FLASH_TICKS : PRESIG_TICKS;
    localparam int MAXT   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW     = $clog2(MAXT + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] wr;
        logic [LW-1:0] len;
        logic [AW-1:0] rd;
        logic [LW-1:0] left;
        logic          newnum;
        logic          flash_pend;
        logic          replay;
        logic          tone;
        logic          hook;
    } ctl_t;

    ctl_t ctl_q;
    ctl_t ctl_d;

    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [CODE_W-1:0] wr_data;
    logic [CODE_W-1:0] rd_data;
    logic              tmr_clear;
    logic              tmr_run;
    logic [TW-1:0]     tmr_limit;
    logic              tmr_expired;
    logic              hook_edge;
    logic              accept;
    logic              add;
    logic              consume;
    logic              left_set;
    logic [LW-1:0]     left_val;
    logic [LW:0]       left_sum;
    logic [LW:0]       left_rem;

    dial_store #(
        .DEPTH  (DEPTH),
        .DATA_W (CODE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (ctl_q.rd),
        .rd_data (rd_data)
    );

    dial_timer #(
        .TW (TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .tick    (tick_1ms),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    // Timer window chosen by the current state.
    always_comb begin
        tmr_run   = 1'b0;
        tmr_limit = '0;
        unique case (ctl_q.st)
            SQ_PRESIG: begin
                tmr_run   = 1'b1;
                tmr_limit = TW'(PRESIG_TICKS);
            end
            SQ_PAUSE: begin
                tmr_run   = 1'b1;
                tmr_limit = ctl_q.tone ? TW'(PAUSE_TONE_TICKS) : TW'(PAUSE_PULSE_TICKS);
            end
            SQ_BREAK: begin
                tmr_run   = 1'b1;
                tmr_limit = TW'(FLASH_TICKS);
            end
            default: begin
                tmr_run   = 1'b0;
                tmr_limit = '0;
            end
        endcase
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.hook = off_hook;
        wr_en      = 1'b0;
        wr_addr    = ctl_q.wr;
        wr_data    = key_code;
        add        = 1'b0;
        consume    = 1'b0;
        left_set   = 1'b0;
        left_val   = '0;
        hook_edge  = (off_hook != ctl_q.hook);
        accept     = key_valid && off_hook && !hook_edge && !ctl_q.flash_pend
                     && (ctl_q.st != SQ_BREAK) && !ctl_q.replay;

        // Key decode: flash request, replay, or an entry to store.
        if (accept) begin
            if (key_code == KEY_FLASH) begin
                ctl_d.flash_pend = 1'b1;
            end else if ((key_code == KEY_PAUSE_REDIAL) && ctl_q.newnum) begin
                if (ctl_q.len != '0) begin
                    ctl_d.rd     = ctl_q.wr - ctl_q.len[AW-1:0];
                    left_set     = 1'b1;
                    left_val     = ctl_q.len;
                    ctl_d.replay = 1'b1;
                end
            end else if ((key_code <= KEY_PAUSE_REDIAL) || (key_code == KEY_TONE_SWITCH)) begin
                wr_en = 1'b1;
                if (ctl_q.newnum) begin
                    wr_addr      = '0;
                    ctl_d.wr     = AW'(1);
                    ctl_d.len    = LW'(1);
                    ctl_d.rd     = '0;
                    left_set     = 1'b1;
                    left_val     = LW'(1);
                    ctl_d.newnum = 1'b0;
                end else begin
                    ctl_d.wr = ctl_q.wr + 1'b1;
                    if (ctl_q.len != LW'(DEPTH)) begin
                        ctl_d.len = ctl_q.len + 1'b1;
                    end
                    add = 1'b1;
                end
            end
        end

        left_rem = {1'b0, ctl_q.left} + (LW+1)'(add) - (LW+1)'(1);

        // Playback sequencing.
        unique case (ctl_q.st)
            SQ_IDLE: begin
                if (ctl_q.left != '0) begin
                    ctl_d.st = SQ_PRESIG;
                end else if (ctl_q.flash_pend) begin
                    ctl_d.st = SQ_BREAK;
                end
            end
            SQ_PRESIG: begin
                if (tmr_expired) begin
                    ctl_d.st = SQ_FETCH;
                end
            end
            SQ_FETCH: begin
                if (rd_data == KEY_PAUSE_REDIAL) begin
                    ctl_d.st = SQ_PAUSE;
                end else if (rd_data == KEY_TONE_SWITCH) begin
                    ctl_d.tone = 1'b1;
                    consume    = 1'b1;
                end else begin
                    ctl_d.st = SQ_ISSUE;
                end
            end
            SQ_ISSUE: begin
                if (sig_done) begin
                    consume = 1'b1;
                end
            end
            SQ_PAUSE: begin
                if (tmr_expired) begin
                    consume = 1'b1;
                end
            end
            SQ_BREAK: begin
                if (tmr_expired) begin
                    ctl_d.st         = SQ_IDLE;
                    ctl_d.flash_pend = 1'b0;
                    ctl_d.newnum     = 1'b1;
                end
            end
            default: ctl_d.st = SQ_IDLE;
        endcase

        if (consume) begin
            ctl_d.rd = ctl_q.rd + 1'b1;
            if (left_rem == '0) begin
                ctl_d.st     = SQ_IDLE;
                ctl_d.replay = 1'b0;
            end else begin
                ctl_d.st = SQ_FETCH;
            end
        end

        left_sum = {1'b0, ctl_q.left} + (LW+1)'(add) - (LW+1)'(consume);
        if (left_set) begin
            ctl_d.left = left_val;
        end else if (left_sum > (LW+1)'(DEPTH)) begin
            ctl_d.left = LW'(DEPTH);
        end else begin
            ctl_d.left = left_sum[LW-1:0];
        end

        // Any hook change abandons the call in progress.
        if (hook_edge) begin
            ctl_d.st         = SQ_IDLE;
            ctl_d.left       = '0;
            ctl_d.flash_pend = 1'b0;
            ctl_d.replay     = 1'b0;
            ctl_d.newnum     = 1'b1;
            ctl_d.tone       = tone_default;
        end
    end

    assign tmr_clear = (ctl_d.st != ctl_q.st) || hook_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.st     <= SQ_IDLE;
            ctl_q.newnum <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dial_req   = (ctl_q.st == SQ_ISSUE);
    assign dial_code  = rd_data;
    assign dial_tone  = ctl_q.tone;
    assign line_break = (ctl_q.st == SQ_BREAK);

    // R2: a pending request keeps its code until the engine answers.
    assert_req_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dial_req && !sig_done && (off_hook == ctl_q.hook)) |=> (dial_req && $stable(dial_code)));

    // R2: only dialable codes ever reach the signalling engine.
    assert_req_dialable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dial_req |-> (dial_code <= KEY_LAST_DIALABLE));

    // R8: a hook change silences both outputs on the next cycle.
    assert_hook_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (off_hook != ctl_q.hook) |=> (!dial_req && !line_break));

    // R11: nothing is signalled while resting on-hook.
    assert_onhook_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!off_hook && !ctl_q.hook) |-> (!dial_req && !line_break));

    // R10: tone mode is left only through a hook change.
    assert_tone_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dial_tone && (off_hook == ctl_q.hook)) |=> dial_tone);

endmodule

// File: tb/redial_sequencer_bench.sv
module redial_sequencer_bench;

    localparam int PRESIG = 8;
    localparam int PTONE  = 3100;
    localparam int PPULSE = 3000;
    localparam int FLASH  = 585;

    localparam logic [3:0] LIVE_KEYS [8] = '{4'd1, 4'd2, 4'd3, 4'd10, 4'd11, 4'd0, 4'd9, 4'd5};
    localparam logic [3:0] REPLAY_EXP [9] = '{4'd1, 4'd2, 4'd3, 4'd10, 4'd11, 4'd0, 4'd9, 4'd5, 4'd4};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b1;
    logic       off_hook = 1'b0;
    logic       tone_default = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic       sig_done = 1'b0;
    logic       dial_req;
    logic [3:0] dial_code;
    logic       dial_tone;
    logic       line_break;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    redial_sequencer u_redial_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_1ms     (tick_1ms),
        .off_hook     (off_hook),
        .tone_default (tone_default),
        .key_valid    (key_valid),
        .key_code     (key_code),
        .sig_done     (sig_done),
        .dial_req     (dial_req),
        .dial_code    (dial_code),
        .dial_tone    (dial_tone),
        .line_break   (line_break)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] c);
        @(negedge clk);
        key_code  = c;
        key_valid = 1'b1;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic wait_req(input int maxc, output int cyc, output bit got);
        cyc = 0;
        got = 1'b0;
        while (!got && cyc < maxc) begin
            if (dial_req) got = 1'b1;
            else begin
                @(negedge clk);
                cyc++;
            end
        end
    endtask

    task automatic finish_digit();
        @(negedge clk);
        sig_done = 1'b1;
        @(negedge clk);
        sig_done = 1'b0;
    endtask

    task automatic expect_digit(input logic [3:0] exp, input string req);
        int  cyc;
        bit  got;
        wait_req(4000, cyc, got);
        check(got && dial_code == exp, req, got ? int'(dial_code) : -1, int'(exp));
        if (got) finish_digit();
    endtask

    task automatic quiet(input int n, input string req);
        int cnt = 0;
        repeat (n) begin
            @(negedge clk);
            if (dial_req) cnt++;
        end
        check(cnt == 0, req, cnt, 0);
    endtask

    task automatic hook_cycle(input logic tone);
        @(negedge clk);
        off_hook = 1'b0;
        repeat (3) @(negedge clk);
        tone_default = tone;
        off_hook = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int  cyc;
        bit  got;
        int  n;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!dial_req && !line_break, "R1", int'(dial_req) + int'(line_break), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dial_req && !line_break, "R1", int'(dial_req) + int'(line_break), 0);

        // R8: off-hook loads pulse mode
        off_hook = 1'b1;
        repeat (2) @(negedge clk);
        check(dial_tone == 1'b0, "R8", int'(dial_tone), 0);

        // R9: replay with nothing stored
        press(4'd12);
        quiet(50, "R9");

        // R2: table of live keys, latency and order
        for (int i = 0; i < 8; i++) begin
            press(LIVE_KEYS[i]);
            wait_req(40, cyc, got);
            check(got && dial_code == LIVE_KEYS[i], "R2", got ? int'(dial_code) : -1, int'(LIVE_KEYS[i]));
            check(got && cyc >= PRESIG && cyc <= PRESIG + 4, "R2", cyc, PRESIG + 2);
            if (i == 0) begin
                repeat (20) @(negedge clk);
                check(dial_req && dial_code == LIVE_KEYS[0], "R2", int'(dial_req), 1);
            end
            if (got) finish_digit();
        end

        // R3: pause in pulse mode keyed while a digit is still pending
        press(4'd4);
        wait_req(40, cyc, got);
        press(4'd12);
        press(4'd6);
        check(got && dial_code == 4'd4, "R3", int'(dial_code), 4);
        finish_digit();
        wait_req(PPULSE + 50, cyc, got);
        check(got && cyc >= PPULSE - 2 && cyc <= PPULSE + 6, "R3", cyc, PPULSE + 1);
        check(got && dial_code == 4'd6, "R3", int'(dial_code), 6);
        if (got) finish_digit();

        // R4: replay after on-hook in tone mode, keys ignored meanwhile (R9 survival)
        hook_cycle(1'b1);
        check(dial_tone == 1'b1, "R8", int'(dial_tone), 1);
        press(4'd12);
        for (int i = 0; i < 9; i++) begin
            expect_digit(REPLAY_EXP[i], "R4");
            if (i == 2) press(4'd7);
        end
        wait_req(PTONE + 50, cyc, got);
        check(got && cyc >= PTONE - 2 && cyc <= PTONE + 6, "R3", cyc, PTONE + 1);
        check(got && dial_code == 4'd6, "R9", int'(dial_code), 6);
        if (got) finish_digit();
        quiet(50, "R4");

        // R8: hook change aborts a replay
        hook_cycle(1'b0);
        press(4'd12);
        wait_req(40, cyc, got);
        check(got && dial_code == 4'd1, "R4", int'(dial_code), 1);
        off_hook = 1'b0;
        @(negedge clk);
        check(!dial_req, "R8", int'(dial_req), 0);
        repeat (2) @(negedge clk);
        off_hook = 1'b1;
        quiet(50, "R8");

        // R6: flash break length, keys ignored during it
        press(4'd13);
        n = 0;
        while (!line_break && n < 10) begin
            @(negedge clk);
            n++;
        end
        check(line_break, "R6", int'(line_break), 1);
        n = 0;
        while (line_break && n < 1000) begin
            key_code  = 4'd8;
            key_valid = (n == 100);
            @(negedge clk);
            n++;
        end
        key_valid = 1'b0;
        check(n >= FLASH - 2 && n <= FLASH + 3, "R6", n, FLASH);
        quiet(40, "R6");

        // R7: replay after flash still finds the old number
        press(4'd12);
        expect_digit(4'd1, "R7");
        hook_cycle(1'b0);

        // R7: digit after a flash starts a new number
        press(4'd3);
        expect_digit(4'd3, "R7");
        press(4'd13);
        n = 0;
        while (!line_break && n < 10) begin
            @(negedge clk);
            n++;
        end
        while (line_break) @(negedge clk);
        press(4'd7);
        expect_digit(4'd7, "R7");
        hook_cycle(1'b0);
        press(4'd12);
        expect_digit(4'd7, "R7");
        quiet(60, "R7");

        // R5: wrap after 40 digits keeps the last 32
        hook_cycle(1'b0);
        for (int i = 0; i < 40; i++) begin
            press(4'(i % 10));
            expect_digit(4'(i % 10), "R5");
        end
        hook_cycle(1'b0);
        press(4'd12);
        for (int i = 8; i < 40; i++) begin
            expect_digit(4'(i % 10), "R5");
        end
        quiet(60, "R5");

        // R10: tone-switch marker, live and on replay
        hook_cycle(1'b0);
        press(4'd2);
        expect_digit(4'd2, "R10");
        press(4'd14);
        repeat (20) @(negedge clk);
        check(dial_tone == 1'b1, "R10", int'(dial_tone), 1);
        press(4'd3);
        expect_digit(4'd3, "R10");
        hook_cycle(1'b0);
        check(dial_tone == 1'b0, "R8", int'(dial_tone), 0);
        press(4'd12);
        wait_req(40, cyc, got);
        check(got && dial_code == 4'd2 && !dial_tone, "R10", int'(dial_tone), 0);
        if (got) finish_digit();
        wait_req(40, cyc, got);
        check(got && dial_code == 4'd3 && dial_tone, "R10", int'(dial_tone), 1);
        if (got) finish_digit();

        // R11: on-hook keys and code 15 ignored, number unchanged
        @(negedge clk);
        off_hook = 1'b0;
        repeat (3) @(negedge clk);
        press(4'd5);
        quiet(30, "R11");
        tone_default = 1'b0;
        off_hook = 1'b1;
        repeat (2) @(negedge clk);
        press(4'd15);
        quiet(30, "R11");
        press(4'd12);
        expect_digit(4'd2, "R11");
        expect_digit(4'd3, "R11");
        quiet(30, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule